// File: doc/BRIEF.md
# Flat Bank Selector with Independent Write Bank

This block sits between a CPU with a 16-bit address space and a memory bus with a 24-bit address. For every memory cycle it drives the eight extended address lines 23..16. The upper bits of that byte are a fixed base value set at build time. The low bits come from a bank register. No part of the 64 KB space is held fixed, so changing the bank swaps out the whole space in a single step.

A second bank register and a redirect flag let memory writes go to a bank other than the one code runs from. Software sets the write bank, turns redirect on, and copies code or data into that bank. Reads and fetches stay in the current bank the whole time. The three registers are loaded by I/O write cycles to three port numbers. An I/O write to the active-bank port switches banks from the next bus cycle on.

Each clock with `cyc_valid` high is one bus cycle. The extended address depends on combinational logic from the registers, so a register loaded at the end of one cycle governs the next cycle.

Top module: `bank_sel_top`

## Requirements
- R1: After reset the active bank and the write bank are 0 and redirect is off. A fetch therefore gives `ext_addr` = {BASE, 2'b00}, and so does a memory write.
- R2: Fetch (kind 0) and read (kind 1) cycles drive `ext_oe`=1 and put the active bank in `ext_addr[1:0]`, whatever the redirect flag and the write bank hold.
- R3: A write cycle (kind 2) puts the write bank in `ext_addr[1:0]` when redirect is on. When redirect is off it puts the active bank there.
- R4: An I/O write (kind 4) to port ACT_PORT (default 8'h60) loads `cpu_wdata[1:0]` into the active bank. The next bus cycle uses the new bank.
- R5: The bank in use does not depend on the CPU address. Addresses 16'h0000, 16'h4000, 16'h8000, 16'hC000 and 16'hFFFF all map through the same bank.
- R6: While `ext_oe` is 1, `ext_addr[7:2]` equals the BASE parameter (default 6'h05). With bank b this gives `ext_addr` = 8'h14 + b.
- R7: I/O read (kind 3), I/O write (kind 4), interrupt acknowledge (kind 5), reserved kinds 6 and 7, and clocks with `cyc_valid`=0 drive `ext_oe`=0 and `ext_addr`=0.
- R8: Only `cpu_wdata[1:0]` is used for a bank register. An I/O write to any other port number, or any non-I/O-write cycle, leaves all three registers unchanged.
- R9: An I/O write to port MODE_PORT (default 8'h62) sets redirect from `cpu_wdata[0]`. A write to port WRB_PORT (default 8'h61) loads the write bank and has no effect on reads or fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_valid | input | 1 | A bus cycle is in progress this clock |
| cyc_kind | input | 3 | 0 fetch, 1 read, 2 write, 3 I/O read, 4 I/O write, 5 interrupt ack, 6-7 reserved |
| cpu_addr | input | 16 | CPU address; bits 7..0 hold the port number in I/O cycles |
| cpu_wdata | input | 8 | CPU write data |
| ext_addr | output | 8 | Extended address bits 23..16 |
| ext_oe | output | 1 | Extended address lines are driven |

## Verification
A bank switch and a redirected write can fall on back-to-back cycles. The register update from the I/O write lands at the same edge that starts the memory write, and that write must follow the write bank rather than the active bank that has just changed. The bench sets up this case directly: with redirect on, an I/O write to the active-bank port is followed at once by a memory write and then a fetch. The write must show the write bank, and the fetch must show the new active bank. A reset applied while all three registers are non-zero checks that a bank switch and a redirect left over from before the reset cannot reach the first cycles after it.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  typedef enum logic [2:0] {
    CK_FETCH = 3'd0,
    CK_READ  = 3'd1,
    CK_WRITE = 3'd2,
    CK_IORD  = 3'd3,
    CK_IOWR  = 3'd4,
    CK_INTA  = 3'd5,
    CK_RSV6  = 3'd6,
    CK_RSV7  = 3'd7
  } cyc_kind_e;
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsel_regs.sv
module bsel_regs #(
  parameter int                BANK_W    = 2,
  parameter int                DATA_W    = 8,
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] ACT_PORT  = 8'h60,
  parameter logic [PORT_W-1:0] WRB_PORT  = 8'h61,
  parameter logic [PORT_W-1:0] MODE_PORT = 8'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  output logic [BANK_W-1:0] act_bank,
  output logic [BANK_W-1:0] wr_bank,
  output logic              redir
);
  logic              act_en, wrb_en, mode_en;
  logic [BANK_W-1:0] act_d, wrb_d;
  logic              redir_d;
  logic              unused_data;

  assign unused_data = ^io_data[DATA_W-1:BANK_W];

  always_comb begin
    act_en  = io_we && (io_port == ACT_PORT);
    wrb_en  = io_we && (io_port == WRB_PORT);
    mode_en = io_we && (io_port == MODE_PORT);
    act_d   = io_data[BANK_W-1:0];
    wrb_d   = io_data[BANK_W-1:0];
    redir_d = io_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bank <= '0;
      wr_bank  <= '0;
      redir    <= 1'b0;
    end else begin
      if (act_en)  act_bank <= act_d;
      if (wrb_en)  wr_bank  <= wrb_d;
      if (mode_en) redir    <= redir_d;
    end
  end
endmodule

// File: rtl/bsel_route.sv
module bsel_route
  import bsel_pkg::*;
#(
  parameter int                       BANK_W = 2,
  parameter int                       EXT_W  = 8,
  parameter logic [EXT_W-BANK_W-1:0]  BASE   = 6'h05
) (
  input  logic              cyc_valid,
  input  cyc_kind_e         cyc_kind,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic              redir,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              ext_oe
);
  logic              is_mem;
  logic              use_wrb;
  logic [BANK_W-1:0] sel_bank;

  always_comb begin
    is_mem   = cyc_valid && (cyc_kind == CK_FETCH || cyc_kind == CK_READ ||
                             cyc_kind == CK_WRITE);
    use_wrb  = cyc_valid && (cyc_kind == CK_WRITE) && redir;
    sel_bank = use_wrb ? wr_bank : act_bank;
    ext_oe   = is_mem;
    ext_addr = is_mem ? {BASE, sel_bank} : '0;
  end
endmodule

// File: rtl/bank_sel_top.sv
module bank_sel_top
  import bsel_pkg::*;
#(
  parameter int                       BANK_W    = 2,
  parameter int                       EXT_W     = 8,
  parameter int                       ADDR_W    = 16,
  parameter int                       DATA_W    = 8,
  parameter int                       PORT_W    = 8,
  parameter logic [EXT_W-BANK_W-1:0]  BASE      = 6'h05,
  parameter logic [PORT_W-1:0]        ACT_PORT  = 8'h60,
  parameter logic [PORT_W-1:0]        WRB_PORT  = 8'h61,
  parameter logic [PORT_W-1:0]        MODE_PORT = 8'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [2:0]        cyc_kind,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              ext_oe
);
  logic              rst_int_n;
  cyc_kind_e         kind;
  logic              io_we;
  logic [BANK_W-1:0] act_bank, wr_bank;
  logic              redir;
  logic              unused_addr;

  assign kind        = cyc_kind_e'(cyc_kind);
  assign io_we       = cyc_valid && (kind == CK_IOWR);
  assign unused_addr = ^cpu_addr[ADDR_W-1:PORT_W];

  bsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_int_n)
  );

  bsel_regs #(
    .BANK_W(BANK_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
    .ACT_PORT(ACT_PORT), .WRB_PORT(WRB_PORT), .MODE_PORT(MODE_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .io_we(io_we),
    .io_port(cpu_addr[PORT_W-1:0]), .io_data(cpu_wdata),
    .act_bank(act_bank), .wr_bank(wr_bank), .redir(redir)
  );

  bsel_route #(.BANK_W(BANK_W), .EXT_W(EXT_W), .BASE(BASE)) u_route (
    .cyc_valid(cyc_valid), .cyc_kind(kind),
    .act_bank(act_bank), .wr_bank(wr_bank), .redir(redir),
    .ext_addr(ext_addr), .ext_oe(ext_oe)
  );
endmodule

// File: rtl/bsel_chk.sv
module bsel_chk #(
  parameter int                       BANK_W   = 2,
  parameter int                       EXT_W    = 8,
  parameter int                       ADDR_W   = 16,
  parameter int                       DATA_W   = 8,
  parameter int                       PORT_W   = 8,
  parameter logic [EXT_W-BANK_W-1:0]  BASE     = 6'h05,
  parameter logic [PORT_W-1:0]        ACT_PORT = 8'h60
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cyc_valid,
  input logic [2:0]        cyc_kind,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [EXT_W-1:0]  ext_addr,
  input logic              ext_oe,
  input logic [BANK_W-1:0] act_bank,
  input logic [BANK_W-1:0] wr_bank,
  input logic              redir
);
  logic armed;
  logic is_rd, is_wr, is_io_wr, is_quiet, act_load;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    is_rd    = cyc_valid && (cyc_kind == 3'd0 || cyc_kind == 3'd1);
    is_wr    = cyc_valid && (cyc_kind == 3'd2);
    is_io_wr = cyc_valid && (cyc_kind == 3'd4);
    is_quiet = !cyc_valid || (cyc_kind >= 3'd3);
    act_load = is_io_wr && (cpu_addr[PORT_W-1:0] == ACT_PORT);
  end

  AST_QUIET_NONMEM: assert property (@(posedge clk) disable iff (!rst_q)
    is_quiet |-> (!ext_oe && ext_addr == '0)); // R7
  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_q)
    ext_oe |-> (ext_addr[EXT_W-1:BANK_W] == BASE)); // R6
  AST_READ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_q)
    is_rd |-> (ext_oe && ext_addr[BANK_W-1:0] == act_bank)); // R2
  AST_WRITE_REDIR: assert property (@(posedge clk) disable iff (!rst_q)
    (is_wr && redir) |-> (ext_addr[BANK_W-1:0] == wr_bank)); // R3
  AST_SWITCH_NEXT: assert property (@(posedge clk) disable iff (!rst_q)
    (armed && $past(act_load)) |-> (act_bank == $past(cpu_wdata[BANK_W-1:0]))); // R4
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (armed && !$past(is_io_wr)) |-> ($stable(act_bank) && $stable(wr_bank) && $stable(redir))); // R8
endmodule

bind bank_sel_top bsel_chk #(
  .BANK_W(BANK_W), .EXT_W(EXT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PORT_W(PORT_W), .BASE(BASE), .ACT_PORT(ACT_PORT)
) u_chk (
  .clk(clk), .rst_q(rst_int_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ext_addr(ext_addr),
  .ext_oe(ext_oe), .act_bank(act_bank), .wr_bank(wr_bank), .redir(redir)
);

// File: tb/sim_bank_sel_top.sv
`timescale 1ns/1ps
module sim_bank_sel_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_valid;
  logic [2:0]  cyc_kind;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  ext_addr;
  logic        ext_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bank_sel_top u0 (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .ext_addr(ext_addr), .ext_oe(ext_oe)
  );

  // {req[3:0], valid, kind[2:0], addr[15:0], data[7:0], exp_oe, exp_ext[7:0]}
  localparam int NV = 20;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1, 1'b1, 3'd0, 16'h0000, 8'h00, 1'b1, 8'h14}, // R1 fetch bank 0
    {4'd1, 1'b1, 3'd2, 16'h1234, 8'hAA, 1'b1, 8'h14}, // R1 write, no redirect
    {4'd7, 1'b1, 3'd4, 16'h0061, 8'h02, 1'b0, 8'h00}, // R7 io write: write bank 2
    {4'd3, 1'b1, 3'd2, 16'h2000, 8'h00, 1'b1, 8'h14}, // R3 redirect off -> active
    {4'd7, 1'b1, 3'd4, 16'h0062, 8'h01, 1'b0, 8'h00}, // R7 io write: redirect on
    {4'd3, 1'b1, 3'd2, 16'h2000, 8'h00, 1'b1, 8'h16}, // R3 redirect on -> write bank
    {4'd2, 1'b1, 3'd1, 16'h2000, 8'h00, 1'b1, 8'h14}, // R2 read stays active
    {4'd2, 1'b1, 3'd0, 16'hFFFF, 8'h00, 1'b1, 8'h14}, // R2 fetch stays active
    {4'd7, 1'b1, 3'd4, 16'hAB60, 8'hFD, 1'b0, 8'h00}, // R7 io write act = 1
    {4'd4, 1'b1, 3'd0, 16'h0000, 8'h00, 1'b1, 8'h15}, // R4 R8 new bank, low bits only
    {4'd5, 1'b1, 3'd1, 16'hC000, 8'h00, 1'b1, 8'h15}, // R5
    {4'd5, 1'b1, 3'd1, 16'h8000, 8'h00, 1'b1, 8'h15}, // R5
    {4'd3, 1'b1, 3'd2, 16'hFFFF, 8'h00, 1'b1, 8'h16}, // R3
    {4'd7, 1'b1, 3'd5, 16'h0000, 8'h00, 1'b0, 8'h00}, // R7 interrupt ack
    {4'd7, 1'b1, 3'd3, 16'h0060, 8'h03, 1'b0, 8'h00}, // R7 io read
    {4'd8, 1'b1, 3'd4, 16'h0063, 8'h03, 1'b0, 8'h00}, // R8 other port
    {4'd8, 1'b1, 3'd0, 16'h4000, 8'h00, 1'b1, 8'h15}, // R8 unchanged
    {4'd9, 1'b1, 3'd4, 16'h0062, 8'hFE, 1'b0, 8'h00}, // R9 redirect off (bit0=0)
    {4'd9, 1'b1, 3'd2, 16'h4000, 8'h00, 1'b1, 8'h15}, // R9 write -> active
    {4'd7, 1'b0, 3'd0, 16'h0000, 8'h00, 1'b0, 8'h00}  // R7 idle clock
  };

  task automatic check(input string tag, input logic [7:0] exp_ext, input logic exp_oe);
    checks++;
    if (ext_oe !== exp_oe || ext_addr !== exp_ext) begin
      fails++;
      $display("FAIL %s: got oe=%0b ext=%02h, expected oe=%0b ext=%02h",
               tag, ext_oe, ext_addr, exp_oe, exp_ext);
    end
  endtask

  task automatic cycle(input logic v, input logic [2:0] k, input logic [15:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    cyc_valid = v; cyc_kind = k; cpu_addr = a; cpu_wdata = d;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cyc_valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_valid = 1'b0; cyc_kind = 3'd0;
    cpu_addr = '0; cpu_wdata = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][36], VEC[i][35:33], VEC[i][32:17], VEC[i][16:9]);
      check($sformatf("R%0d vec%0d", VEC[i][40:37], i), VEC[i][7:0], VEC[i][8]);
    end

    // R1: reset clears a non-zero state
    cycle(1'b1, 3'd4, 16'h0060, 8'h03);
    cycle(1'b1, 3'd4, 16'h0061, 8'h01);
    cycle(1'b1, 3'd4, 16'h0062, 8'h01);
    do_reset();
    cycle(1'b1, 3'd0, 16'h0100, 8'h00);
    check("R1 fetch after reset", 8'h14, 1'b1);
    cycle(1'b1, 3'd2, 16'h0100, 8'h00);
    check("R1 write after reset", 8'h14, 1'b1);

    // R3/R4: switch followed at once by a redirected write
    cycle(1'b1, 3'd4, 16'h0061, 8'h02);
    cycle(1'b1, 3'd4, 16'h0062, 8'h01);
    cycle(1'b1, 3'd4, 16'h0060, 8'h03);
    cycle(1'b1, 3'd2, 16'h8000, 8'h55);
    check("R3 write right after switch", 8'h16, 1'b1);
    cycle(1'b1, 3'd0, 16'h8000, 8'h00);
    check("R4 fetch after switch", 8'h17, 1'b1);
    // R9: write-bank load leaves reads alone
    cycle(1'b1, 3'd4, 16'h0061, 8'h00);
    cycle(1'b1, 3'd1, 16'h0000, 8'h00);
    check("R9 read after write-bank load", 8'h17, 1'b1);
    cycle(1'b1, 3'd2, 16'h0000, 8'h00);
    check("R9 write uses new write bank", 8'h14, 1'b1);
    // R7 reserved kind, R5/R6 top of space
    cycle(1'b1, 3'd7, 16'h0060, 8'h00);
    check("R7 reserved kind", 8'h00, 1'b0);
    cycle(1'b1, 3'd0, 16'hFFFF, 8'h00);
    check("R5 R6 top address", 8'h17, 1'b1);

    cycle(1'b0, 3'd0, 16'h0000, 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule